// File: doc/BRIEF.md
# Memory Retention Reset Sequencer

This block orders the steps of a board reset so that the contents of main memory can survive any reset except power-on. Software sets or clears a one-bit retention flag through a small write/read port. Only the power-on reset clears this flag, so software reads it after start-up to decide whether to keep the retained memory area while it sets up memory.

Other reset sources raise request lines. If the flag is set when a request arrives, the block first pulls an active-low interrupt line. The processor uses that interrupt to put its DRAM into self-refresh. After a fixed notice interval the block drives the active-low system reset and holds it for a minimum time. If the flag is clear, the system reset starts at once and no interrupt is raised. A sequence cannot be interrupted once it has started. The notice interval is 1 ms and the hold time is 50 ms. Both are counted in clock cycles derived from a clock-frequency parameter: `DELAY_CYC = CLK_HZ/1000` and `HOLD_CYC = CLK_HZ/20`.

Top module: `pmem_reset_seq`

## Requirements
- R1: A cycle with `wr_en` high loads `wr_data` into the retention flag. `rd_data` shows the new value from the next cycle on.
- R2: While `por_n` is low at a clock edge, the flag clears to 0 (retention disabled), `irq_n` goes high and `sys_rst_n` goes high. This applies even if a sequence is running.
- R3: The flag changes only by a write or by power-on reset. A reset sequence leaves it as it was.
- R4: Suppose any bit of `rst_req` is high at an edge in idle, and the flag held 1 before that edge. Then `irq_n` goes low after that edge and `sys_rst_n` stays high. A write on that same edge does not change this choice.
- R5: `sys_rst_n` goes low exactly `DELAY_CYC` cycles after `irq_n` went low.
- R6: Once `sys_rst_n` is low, it stays low for exactly `HOLD_CYC` cycles and then returns high.
- R7: Suppose a request is seen in idle and the flag held 0. Then `sys_rst_n` goes low after that edge, and `irq_n` stays high for the whole sequence.
- R8: In a retention sequence, `irq_n` stays low until the edge at which `sys_rst_n` is released. It goes high on that same edge.
- R9: Requests that arrive during a notice or hold interval are ignored and are not stored. A request seen after release starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| wr_en | input | 1 | Write strobe for the retention flag |
| wr_data | input | 1 | Value written to the retention flag |
| rst_req | input | N_SRC | Reset request lines from non-power-on sources, active high |
| rd_data | output | 1 | Current retention flag |
| irq_n | output | 1 | Self-refresh interrupt to the processor, active low |
| sys_rst_n | output | 1 | System reset output, active low |

## Verification
Two cases are hard to reach from the ports. The first is a request that arrives on the same edge as a write that changes the flag. The bench drives both strobes in one cycle, and the sequence must follow the old value while `rd_data` shows the new one. The second is requests that land in the middle of the notice and hold intervals. The bench pulses every request line deep inside each interval and then watches for a run of idle cycles after release. Power-on reset is also dropped in the middle of a notice interval, to show that it alone clears the flag and stops the sequence.

// File: rtl/pmr_pkg.sv
// Package: shared state encoding for the retention reset sequencer.
package pmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_NOTIFY = 2'd1,
        ST_HOLD   = 2'd2
    } pmr_state_e;
endpackage

// File: rtl/pmr_retain_flag.sv
// Module: pmr_retain_flag
// Holds the software retention flag. Only the power-on reset clears it.
// Assumes: writes are single-cycle strobes synchronous to clk.
module pmr_retain_flag (
    input  logic clk,
    input  logic por_n,
    input  logic wr_en,
    input  logic wr_data,
    output logic flag_q
);
    // Flag register: power-on clears it, a write strobe loads it.
    always_ff @(posedge clk) begin
        if (!por_n)     flag_q <= 1'b0;
        else if (wr_en) flag_q <= wr_data;
    end
endmodule

// File: rtl/pmr_interval_ctr.sv
// Module: pmr_interval_ctr
// Up-counter for the notice and hold intervals. hit is high while the
// count equals last.
// Assumes: the caller clears the counter at the start of every interval.
module pmr_interval_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] last,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: clears on request, otherwise advances by one.
    always_ff @(posedge clk) begin
        if (!por_n || clr) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // Compare against the interval's final count.
    always_comb hit = (cnt_q == last);
endmodule

// File: rtl/pmr_seq_fsm.sv
// Module: pmr_seq_fsm
// Reset sequence controller: idle -> notice (interrupt only) -> hold
// (reset driven). It skips the notice state when retention is off.
// Assumes: DELAY_CYC >= 1 and HOLD_CYC >= 1, and both fit in CNT_W bits.
module pmr_seq_fsm
    import pmr_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int DELAY_CYC = 4,
    parameter int HOLD_CYC  = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             req,
    input  logic             retain,
    input  logic             hit,
    output logic             cnt_clr,
    output logic [CNT_W-1:0] cnt_last,
    output logic             irq_n,
    output logic             sys_rst_n
);
    localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

    pmr_state_e state_q, state_d;
    logic       with_irq_q, with_irq_d;

    // Next-state logic: start on a request in idle, advance when an interval ends.
    always_comb begin
        state_d    = state_q;
        with_irq_d = with_irq_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    with_irq_d = retain;
                    state_d    = retain ? ST_NOTIFY : ST_HOLD;
                end
            end
            ST_NOTIFY: if (hit) state_d = ST_HOLD;
            ST_HOLD: begin
                if (hit) begin
                    state_d    = ST_IDLE;
                    with_irq_d = 1'b0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State registers: power-on returns the controller to idle.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q    <= ST_IDLE;
            with_irq_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            with_irq_q <= with_irq_d;
        end
    end

    // Counter control: keep it cleared in idle, restart it at each interval end.
    always_comb begin
        cnt_clr  = (state_q == ST_IDLE) || hit;
        cnt_last = (state_q == ST_NOTIFY) ? DELAY_LAST : HOLD_LAST;
    end

    // Output decode: interrupt through notice and retained hold, reset in hold.
    always_comb begin
        irq_n     = !((state_q == ST_NOTIFY) || ((state_q == ST_HOLD) && with_irq_q));
        sys_rst_n = !(state_q == ST_HOLD);
    end
endmodule

// File: rtl/pmem_reset_seq.sv
// Module: pmem_reset_seq (top)
// Retention flag plus reset sequencer. It derives the cycle counts for the
// 1 ms notice and the 50 ms hold from CLK_HZ.
// Assumes: CLK_HZ >= 1000 and request lines synchronous to clk.
module pmem_reset_seq #(
    parameter int CLK_HZ = 100_000_000,
    parameter int N_SRC  = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic             wr_data,
    input  logic [N_SRC-1:0] rst_req,
    output logic             rd_data,
    output logic             irq_n,
    output logic             sys_rst_n
);
    localparam int DELAY_CYC = CLK_HZ / 1000;
    localparam int HOLD_CYC  = CLK_HZ / 20;
    localparam int CNT_W     = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    logic             any_req;
    logic             cnt_clr;
    logic             cnt_hit;
    logic [CNT_W-1:0] cnt_last;

    // Merge the request sources into one request.
    always_comb any_req = |rst_req;

    pmr_retain_flag u_flag (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .flag_q  (rd_data)
    );

    pmr_interval_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .por_n (por_n),
        .clr   (cnt_clr),
        .last  (cnt_last),
        .hit   (cnt_hit)
    );

    pmr_seq_fsm #(
        .CNT_W     (CNT_W),
        .DELAY_CYC (DELAY_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .req       (any_req),
        .retain    (rd_data),
        .hit       (cnt_hit),
        .cnt_clr   (cnt_clr),
        .cnt_last  (cnt_last),
        .irq_n     (irq_n),
        .sys_rst_n (sys_rst_n)
    );
endmodule

// File: rtl/pmr_checker.sv
// Module: pmr_checker
// Port-level properties of the sequencer, bound to pmem_reset_seq.
// Assumes: por_n is held low for at least one edge at start-up.
module pmr_checker #(
    parameter int CLK_HZ = 100_000_000,
    parameter int N_SRC  = 3
) (
    input logic             clk,
    input logic             por_n,
    input logic             wr_en,
    input logic             wr_data,
    input logic [N_SRC-1:0] rst_req,
    input logic             rd_data,
    input logic             irq_n,
    input logic             sys_rst_n
);
    localparam int DELAY_CYC = CLK_HZ / 1000;
    localparam int HOLD_CYC  = CLK_HZ / 20;

    int irq_lo_cnt;
    int rst_lo_cnt;

    // Count notice cycles (interrupt low, reset still high).
    always_ff @(posedge clk) begin
        if (!por_n || irq_n) irq_lo_cnt <= 0;
        else if (sys_rst_n)  irq_lo_cnt <= irq_lo_cnt + 1;
    end

    // Count cycles with the system reset driven low.
    always_ff @(posedge clk) begin
        if (!por_n || sys_rst_n) rst_lo_cnt <= 0;
        else                     rst_lo_cnt <= rst_lo_cnt + 1;
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!por_n)
        wr_en |=> (rd_data == $past(wr_data))); // R1
    AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> $stable(rd_data)); // R3
    AST_IRQ_LEADS: assert property (@(posedge clk) disable iff (!por_n)
        $fell(irq_n) |-> (sys_rst_n && $past(|rst_req) && $past(rd_data))); // R4
    AST_NOTICE_LEN: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(sys_rst_n) && !irq_n) |-> (irq_lo_cnt == DELAY_CYC)); // R5
    AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> (rst_lo_cnt == HOLD_CYC)); // R6
    AST_DIRECT_RESET: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(sys_rst_n) && irq_n) |-> ($past(|rst_req) && !$past(rd_data) && $past(irq_n))); // R7
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!por_n)
        !irq_n |=> (!irq_n || $rose(sys_rst_n))); // R8
    AST_IRQ_RELEASED: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sys_rst_n) |-> irq_n); // R8
endmodule

bind pmem_reset_seq pmr_checker #(.CLK_HZ(CLK_HZ), .N_SRC(N_SRC)) u_pmr_checker (
    .clk       (clk),
    .por_n     (por_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rst_req   (rst_req),
    .rd_data   (rd_data),
    .irq_n     (irq_n),
    .sys_rst_n (sys_rst_n)
);

// File: tb/test_pmem_reset_seq.sv
// Bench for pmem_reset_seq. A behavioural reference model is compared with
// the design on every clock, and directed checks measure the intervals.
module test_pmem_reset_seq;
    localparam int CLK_HZ = 100_000;
    localparam int N_SRC  = 3;
    localparam int DELAY  = CLK_HZ / 1000;
    localparam int HOLD   = CLK_HZ / 20;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             wr_data = 1'b0;
    logic [N_SRC-1:0] rst_req = '0;
    logic             rd_data, irq_n, sys_rst_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_en = 0;

    always #5 clk = ~clk;

    pmem_reset_seq #(.CLK_HZ(CLK_HZ), .N_SRC(N_SRC)) i_pmem_reset_seq (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
        .rst_req(rst_req), .rd_data(rd_data), .irq_n(irq_n), .sys_rst_n(sys_rst_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Reference model: mode 0 idle, 1 notice, 2 hold; m_left = cycles remaining.
    int m_mode = 0;
    int m_left = 0;
    bit m_ret = 0;
    bit m_wi = 0;
    always @(posedge clk) begin
        if (!por_n) begin
            m_mode = 0; m_left = 0; m_ret = 0; m_wi = 0;
        end else begin
            if (m_mode == 0) begin
                if (|rst_req) begin
                    m_wi   = m_ret;
                    m_mode = m_ret ? 1 : 2;
                    m_left = m_ret ? DELAY : HOLD;
                end
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_mode == 1) begin m_mode = 2; m_left = HOLD; end
                    else begin m_mode = 0; m_wi = 0; end
                end
            end
            if (wr_en) m_ret = wr_data;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R1", rd_data, m_ret);
            chk("R4", irq_n, !((m_mode == 1) || (m_mode == 2 && m_wi)));
            chk("R6", sys_rst_n, !(m_mode == 2));
        end
    end

    task automatic write_flag(input logic d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R1", rd_data, d);
    endtask

    // Run one sequence from source src and measure both intervals.
    task automatic run_seq(input int src, input bit exp_irq);
        int n;
        bit saw_irq;
        logic flag0;
        flag0 = rd_data;
        rst_req[src] = 1'b1;
        @(negedge clk);
        rst_req = '0;
        if (exp_irq) begin
            chk("R4", irq_n, 1'b0);
            chk("R4", sys_rst_n, 1'b1);
            n = 0;
            while (sys_rst_n) begin
                rst_req = (n == 10) ? '1 : '0; // R9: ignored in notice
                n++;
                @(negedge clk);
            end
            rst_req = '0;
            chk_int("R5", n, DELAY);
            chk("R8", irq_n, 1'b0);
        end else begin
            chk("R7", sys_rst_n, 1'b0);
            chk("R7", irq_n, 1'b1);
        end
        n = 0;
        saw_irq = 0;
        while (!sys_rst_n) begin
            if (!irq_n) saw_irq = 1;
            rst_req = (n == 100) ? '1 : '0; // R9: ignored in hold
            n++;
            @(negedge clk);
        end
        rst_req = '0;
        chk_int("R6", n, HOLD);
        chk("R8", irq_n, 1'b1);
        if (!exp_irq) chk("R7", saw_irq, 1'b0);
        chk("R3", rd_data, flag0);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            if (!sys_rst_n || !irq_n) n++;
            @(negedge clk);
        end
        chk_int("R9", n, 0);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        cmp_en = 1;
        chk("R2", rd_data, 1'b0);
        chk("R2", irq_n, 1'b1);
        chk("R2", sys_rst_n, 1'b1);
        por_n = 1'b1;
        @(negedge clk);
        write_flag(1'b1);
        write_flag(1'b0);
        write_flag(1'b1);
        run_seq(0, 1'b1);
        write_flag(1'b0);
        run_seq(2, 1'b0);
        // R9: a fresh request after release starts a new sequence
        run_seq(1, 1'b0);
        // R4: write of 0 on the same edge as a request; old value 1 governs
        write_flag(1'b1);
        wr_en = 1'b1; wr_data = 1'b0; rst_req[1] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rst_req = '0;
        chk("R4", irq_n, 1'b0);
        chk("R1", rd_data, 1'b0);
        n = 0;
        while (irq_n == 1'b0 || sys_rst_n == 1'b0) begin n++; @(negedge clk); end
        chk_int("R5", n, DELAY + HOLD);
        chk("R3", rd_data, 1'b0);
        // R2: power-on reset in the middle of a notice interval
        write_flag(1'b1);
        rst_req[0] = 1'b1;
        @(negedge clk);
        rst_req = '0;
        repeat (5) @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        chk("R2", rd_data, 1'b0);
        chk("R2", irq_n, 1'b1);
        chk("R2", sys_rst_n, 1'b1);
        por_n = 1'b1;
        repeat (5) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100_000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule